// File: doc/BRIEF.md
# PCI Type-0 Configuration Header with Aliased Register Window

This block is the configuration-space register file of a single-function PCI target. A simple configuration port reaches it. The port carries a dword register number, four byte enables, write data and a write strobe, and read data comes back combinationally for the selected dword. The block returns the identification, class, revision, header-type and subsystem fields as constants. It keeps a command register, a status register with sticky error bits, and a cache-line-size register.

Two base address registers point at the same 128-byte window of local registers. BAR0 places the window in memory space and BAR1 places it in I/O space. From the programmed bases, the command enables and two external per-BAR enable inputs, the block decodes two bus address inputs into a memory hit and an I/O hit.

The block has no sequencing state. Every register updates on the clock edge that carries a write or an event, and reads and decodes are combinational. So the brief names no states or transitions.

Top module: `pci_cfg_hdr`

## Requirements
- R1: Dword 0 reads {DEVICE_ID, VENDOR_ID}, with the Vendor ID in bits [15:0]. Writes to it have no effect.
- R2: Dword 11 (byte offset 2Ch) reads {SUBSYS_ID, SUBSYS_VID}, with the subsystem vendor in bits [15:0]. Dword 2 reads {CLASS_CODE, REV_ID}. Dword 3 bits [31:8] read zero, so the header type (bits [23:16]) is 00h, meaning single function. All of these ignore writes.
- R3: Dword 4 is the memory BAR. Bits [31:7] are writable base bits under their byte enables, and bits [6:0] read 0. After all ones are written it reads FFFFFF80h.
- R4: Dword 5 is the I/O BAR. Bits [31:7] are writable under their byte enables, bits [6:1] read 0 and bit 0 reads 1. After all ones are written it reads FFFFFF81h.
- R5: The command register is dword 1 bits [15:0]. Only bits 0 (I/O enable), 1 (memory enable), 6 and 8 are writable, each under its byte enable. All other bits read 0.
- R6: mem_hit is 1 exactly when command bit 1 is set, bar0_en is 1, and mem_addr[31:7] equals BAR0[31:7].
- R7: io_hit is 1 exactly when command bit 0 is set, bar1_en is 1, and io_addr[31:7] equals BAR1[31:7].
- R8: With bar0_en or bar1_en at 0, the matching hit output stays 0 for every address and command setting.
- R9: After reset, the command register, the status register, both BAR bases and the cache-line size are zero, and neither hit output asserts.
- R10: Status bits 11..15 (dword 1 bits [27:31]) are set by sts_evt[0..4]. A 1 written to such a bit with byte enable 3 clears it. An event in the same cycle as the clear wins. Writes with byte enable 3 low leave the bits unchanged.
- R11: The cache-line size is dword 3 bits [7:0]. It is read/write under byte enable 0 and counts 32-bit words.
- R12: Dwords other than 0–5 and 11 read zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_num | input | 6 | Dword register number |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of dword cfg_num |
| sts_evt | input | 5 | Error event pulses, bit i sets status bit 11+i |
| bar0_en | input | 1 | External enable for memory BAR decode |
| bar1_en | input | 1 | External enable for I/O BAR decode |
| mem_addr | input | 32 | Memory-space bus address to decode |
| io_addr | input | 32 | I/O-space bus address to decode |
| mem_hit | output | 1 | mem_addr falls in the BAR0 window |
| io_hit | output | 1 | io_addr falls in the BAR1 window |

## Verification
The hardest case to reach from the ports is the full cross of decode conditions. A hit needs a programmed base, the right command bit and the external enable all at once, and a near miss must sit exactly one byte outside the window. The stimulus programs several bases, including all-ones and the top bit alone. For each base it walks all sixteen combinations of the two command enables and the two external enables, and probes five addresses around the window edges. A second hard case is a status event that lands in the same cycle as a write-one-to-clear. The bench drives both on the same edge.

// File: rtl/pci_cfg_hdr_pkg.sv
package pci_cfg_hdr_pkg;

    localparam int DW        = 32;
    localparam int NUM_W     = 6;
    localparam int BE_W      = DW / 8;

    localparam logic [NUM_W-1:0] REG_ID     = 6'd0;
    localparam logic [NUM_W-1:0] REG_CMDSTS = 6'd1;
    localparam logic [NUM_W-1:0] REG_CLASS  = 6'd2;
    localparam logic [NUM_W-1:0] REG_MISC   = 6'd3;
    localparam logic [NUM_W-1:0] REG_BAR0   = 6'd4;
    localparam logic [NUM_W-1:0] REG_BAR1   = 6'd5;
    localparam logic [NUM_W-1:0] REG_SUBSYS = 6'd11;

    localparam int CMD_IO_BIT  = 0;
    localparam int CMD_MEM_BIT = 1;

    typedef struct packed {
        logic             wr;
        logic [NUM_W-1:0] num;
        logic [BE_W-1:0]  be;
        logic [DW-1:0]    data;
    } cfg_wreq_t;

endpackage

// File: rtl/pci_cfg_bar.sv
module pci_cfg_bar
    import pci_cfg_hdr_pkg::*;
#(
    parameter bit               IS_IO    = 1'b0,
    parameter int               WIN_LOG2 = 7,
    parameter logic [NUM_W-1:0] MY_REG   = REG_BAR0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  cfg_wreq_t              wreq,
    input  logic                   space_en,
    input  logic                   bar_en,
    input  logic [DW-WIN_LOG2-1:0] addr_hi,
    output logic [DW-1:0]          rdata,
    output logic                   hit
);

    localparam int BASE_W = DW - WIN_LOG2;

    logic [BASE_W-1:0] base_q;
    logic [BASE_W-1:0] base_d;
    logic              sel;

    assign sel = wreq.wr && (wreq.num == MY_REG);

    always_comb begin
        base_d = base_q;
        for (int j = 0; j < BASE_W; j++) begin
            if (wreq.be[(j + WIN_LOG2) / 8]) begin
                base_d[j] = wreq.data[j + WIN_LOG2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (sel) begin
            base_q <= base_d;
        end
    end

    generate
        if (IS_IO) begin : g_io
            assign rdata = {base_q, {(WIN_LOG2-1){1'b0}}, 1'b1};
        end else begin : g_mem
            assign rdata = {base_q, {WIN_LOG2{1'b0}}};
        end
    endgenerate

    assign hit = space_en && bar_en && (addr_hi == base_q);

    AST_BAR_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && (wreq.be == 4'hF)) |=> (rdata[DW-1:WIN_LOG2] == $past(wreq.data[DW-1:WIN_LOG2]))); // R3

    AST_BAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(rdata)); // R12

endmodule

// File: rtl/pci_cfg_status.sv
module pci_cfg_status
    import pci_cfg_hdr_pkg::*;
#(
    parameter int NUM_EVT = 5,
    parameter int STS_LSB = 27
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cfg_wreq_t          wreq,
    input  logic [NUM_EVT-1:0] evt,
    output logic [NUM_EVT-1:0] sts
);

    localparam int BYTE_SEL = STS_LSB / 8;

    logic               wsel;
    logic [NUM_EVT-1:0] clr;

    assign wsel = wreq.wr && (wreq.num == REG_CMDSTS) && wreq.be[BYTE_SEL];
    assign clr  = wsel ? wreq.data[STS_LSB +: NUM_EVT] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts <= (sts & ~clr) | evt;
        end
    end

    AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((sts & $past(evt)) == $past(evt))); // R10

    AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel && (evt == '0)) |=> ((sts & $past(wreq.data[STS_LSB +: NUM_EVT])) == '0)); // R10

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wsel && (evt == '0)) |=> $stable(sts)); // R10

endmodule

// File: rtl/pci_cfg_rdmux.sv
module pci_cfg_rdmux
    import pci_cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
    parameter logic [7:0]  REV_ID     = 8'h05,
    parameter logic [23:0] CLASS_CODE = 24'h118000,
    parameter logic [15:0] SUBSYS_VID = 16'h5E6F,
    parameter logic [15:0] SUBSYS_ID  = 16'h7081,
    parameter int          NUM_EVT    = 5
) (
    input  logic [NUM_W-1:0]   num,
    input  logic [15:0]        cmd,
    input  logic [NUM_EVT-1:0] sts,
    input  logic [7:0]         cls,
    input  logic [DW-1:0]      bar0_rd,
    input  logic [DW-1:0]      bar1_rd,
    output logic [DW-1:0]      rdata
);

    logic [15:0] status_word;

    assign status_word = {sts, {(16-NUM_EVT){1'b0}}};

    always_comb begin
        case (num)
            REG_ID:     rdata = {DEVICE_ID, VENDOR_ID};
            REG_CMDSTS: rdata = {status_word, cmd};
            REG_CLASS:  rdata = {CLASS_CODE, REV_ID};
            REG_MISC:   rdata = {8'h00, 8'h00, 8'h00, cls};
            REG_BAR0:   rdata = bar0_rd;
            REG_BAR1:   rdata = bar1_rd;
            REG_SUBSYS: rdata = {SUBSYS_ID, SUBSYS_VID};
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/pci_cfg_hdr.sv
module pci_cfg_hdr
    import pci_cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
    parameter logic [7:0]  REV_ID     = 8'h05,
    parameter logic [23:0] CLASS_CODE = 24'h118000,
    parameter logic [15:0] SUBSYS_VID = 16'h5E6F,
    parameter logic [15:0] SUBSYS_ID  = 16'h7081,
    parameter logic [15:0] CMD_WMASK  = 16'h0143,
    parameter int          WIN_LOG2   = 7,
    parameter int          NUM_EVT    = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [5:0]   cfg_num,
    input  logic [3:0]   cfg_be,
    input  logic [31:0]  cfg_wdata,
    output logic [31:0]  cfg_rdata,
    input  logic [4:0]   sts_evt,
    input  logic         bar0_en,
    input  logic         bar1_en,
    input  logic [31:0]  mem_addr,
    input  logic [31:0]  io_addr,
    output logic         mem_hit,
    output logic         io_hit
);

    localparam int BASE_W = DW - WIN_LOG2;

    cfg_wreq_t     wreq;
    logic [15:0]   cmd_q;
    logic [15:0]   cmd_bm;
    logic [7:0]    cls_q;
    logic [DW-1:0] bar0_rd;
    logic [DW-1:0] bar1_rd;
    logic          cmd_sel;
    logic          cls_sel;

    assign wreq = '{wr: cfg_wr, num: cfg_num, be: cfg_be, data: cfg_wdata};

    assign cmd_sel = cfg_wr && (cfg_num == REG_CMDSTS);
    assign cls_sel = cfg_wr && (cfg_num == REG_MISC) && cfg_be[0];
    assign cmd_bm  = {{8{cfg_be[1]}}, {8{cfg_be[0]}}} & CMD_WMASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_sel) begin
            cmd_q <= (cmd_q & ~cmd_bm) | (cfg_wdata[15:0] & cmd_bm);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q <= '0;
        end else if (cls_sel) begin
            cls_q <= cfg_wdata[7:0];
        end
    end

    pci_cfg_bar #(
        .IS_IO    (1'b0),
        .WIN_LOG2 (WIN_LOG2),
        .MY_REG   (REG_BAR0)
    ) u_bar_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wreq     (wreq),
        .space_en (cmd_q[CMD_MEM_BIT]),
        .bar_en   (bar0_en),
        .addr_hi  (mem_addr[DW-1:WIN_LOG2]),
        .rdata    (bar0_rd),
        .hit      (mem_hit)
    );

    pci_cfg_bar #(
        .IS_IO    (1'b1),
        .WIN_LOG2 (WIN_LOG2),
        .MY_REG   (REG_BAR1)
    ) u_bar_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .wreq     (wreq),
        .space_en (cmd_q[CMD_IO_BIT]),
        .bar_en   (bar1_en),
        .addr_hi  (io_addr[DW-1:WIN_LOG2]),
        .rdata    (bar1_rd),
        .hit      (io_hit)
    );

    logic [NUM_EVT-1:0] sts_q;

    pci_cfg_status #(
        .NUM_EVT (NUM_EVT),
        .STS_LSB (16 + 16 - NUM_EVT)
    ) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .wreq  (wreq),
        .evt   (sts_evt),
        .sts   (sts_q)
    );

    pci_cfg_rdmux #(
        .VENDOR_ID  (VENDOR_ID),
        .DEVICE_ID  (DEVICE_ID),
        .REV_ID     (REV_ID),
        .CLASS_CODE (CLASS_CODE),
        .SUBSYS_VID (SUBSYS_VID),
        .SUBSYS_ID  (SUBSYS_ID),
        .NUM_EVT    (NUM_EVT)
    ) u_rdmux (
        .num     (cfg_num),
        .cmd     (cmd_q),
        .sts     (sts_q),
        .cls     (cls_q),
        .bar0_rd (bar0_rd),
        .bar1_rd (bar1_rd),
        .rdata   (cfg_rdata)
    );

    AST_MEM_HIT_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> (cmd_q[CMD_MEM_BIT] && bar0_en)); // R6

    AST_IO_HIT_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> (cmd_q[CMD_IO_BIT] && bar1_en)); // R7

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_sel |=> $stable(cmd_q)); // R5

    AST_CMD_RO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cmd_q & ~CMD_WMASK) == 16'h0000)); // R5

    AST_CLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cls_sel |=> $stable(cls_q)); // R11

    AST_BASE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_num == REG_BAR0 && cfg_be == 4'hF) |=> (bar0_rd[BASE_W-1+WIN_LOG2:WIN_LOG2] == $past(cfg_wdata[DW-1:WIN_LOG2]))); // R3

endmodule

// File: tb/pci_cfg_hdr_bench.sv
module pci_cfg_hdr_bench;

    localparam logic [15:0] VID  = 16'h1A2B;
    localparam logic [15:0] DID  = 16'h3C4D;
    localparam logic [7:0]  REV  = 8'h05;
    localparam logic [23:0] CLS  = 24'h118000;
    localparam logic [15:0] SVID = 16'h5E6F;
    localparam logic [15:0] SID  = 16'h7081;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_num = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [4:0]  sts_evt = '0;
    logic        bar0_en = 1'b0;
    logic        bar1_en = 1'b0;
    logic [31:0] mem_addr = '0;
    logic [31:0] io_addr = '0;
    logic        mem_hit;
    logic        io_hit;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pci_cfg_hdr u_pci_cfg_hdr (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_num(cfg_num),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .sts_evt(sts_evt), .bar0_en(bar0_en), .bar1_en(bar1_en),
        .mem_addr(mem_addr), .io_addr(io_addr), .mem_hit(mem_hit), .io_hit(io_hit)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] n, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_num = n; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_read(input logic [5:0] n, output logic [31:0] d);
        cfg_num = n;
        #1;
        d = cfg_rdata;
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = be[b] ? 8'hFF : 8'h00;
        return (old & ~m) | (nw & m);
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] exp;
        logic [31:0] bases [4];
        logic [31:0] probes [5];
        bases[0] = 32'h12345680; bases[1] = 32'hFFFFFF80;
        bases[2] = 32'h00000080; bases[3] = 32'h80000000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        cfg_read(6'd1, rd);  chk("R9 cmd/status", rd, 32'h0);
        cfg_read(6'd4, rd);  chk("R9 bar0", rd, 32'h0);
        cfg_read(6'd5, rd);  chk("R9 bar1", rd, 32'h1);
        cfg_read(6'd3, rd);  chk("R9 cache line", rd, 32'h0);
        bar0_en = 1'b1; bar1_en = 1'b1; #1;
        chk("R9 mem_hit", {31'h0, mem_hit}, 32'h0);
        chk("R9 io_hit", {31'h0, io_hit}, 32'h0);

        // R1 and R2 constants, writes ignored
        cfg_read(6'd0, rd);  chk("R1 ids", rd, {DID, VID});
        cfg_write(6'd0, 4'hF, 32'hFFFFFFFF);
        cfg_read(6'd0, rd);  chk("R1 ids after write", rd, {DID, VID});
        cfg_read(6'd11, rd); chk("R2 subsys", rd, {SID, SVID});
        cfg_write(6'd11, 4'hF, 32'h0);
        cfg_read(6'd11, rd); chk("R2 subsys after write", rd, {SID, SVID});
        cfg_read(6'd2, rd);  chk("R2 class/rev", rd, {CLS, REV});
        cfg_write(6'd2, 4'hF, 32'h0);
        cfg_read(6'd2, rd);  chk("R2 class after write", rd, {CLS, REV});
        cfg_write(6'd3, 4'hE, 32'hFFFFFFFF);
        cfg_read(6'd3, rd);  chk("R2 header type single", rd, 32'h0);

        // R12 unimplemented dwords
        for (int n = 6; n < 64; n++) begin
            if (n != 11) begin
                cfg_write(n[5:0], 4'hF, 32'hFFFFFFFF);
                cfg_read(n[5:0], rd);
                chk("R12 unimplemented reads zero", rd, 32'h0);
            end
        end
        cfg_read(6'd1, rd); chk("R12 cmd untouched", rd, 32'h0);
        cfg_read(6'd4, rd); chk("R12 bar0 untouched", rd, 32'h0);
        cfg_read(6'd3, rd); chk("R12 cache untouched", rd, 32'h0);

        // R3 R4 sizing
        cfg_write(6'd4, 4'hF, 32'hFFFFFFFF);
        cfg_read(6'd4, rd); chk("R3 bar0 sizing", rd, 32'hFFFFFF80);
        cfg_write(6'd5, 4'hF, 32'hFFFFFFFF);
        cfg_read(6'd5, rd); chk("R4 bar1 sizing", rd, 32'hFFFFFF81);

        // R3 R4 byte enable sweep
        for (int be = 0; be < 16; be++) begin
            cfg_write(6'd4, 4'hF, 32'h0);
            cfg_write(6'd4, be[3:0], 32'hA5C396F0);
            exp = merge(32'h0, 32'hA5C396F0, be[3:0]) & 32'hFFFFFF80;
            cfg_read(6'd4, rd); chk("R3 bar0 byte enables", rd, exp);
            cfg_write(6'd5, 4'hF, 32'hFFFFFFFF);
            cfg_write(6'd5, be[3:0], 32'h3C5A69FE);
            exp = (merge(32'hFFFFFFFF, 32'h3C5A69FE, be[3:0]) & 32'hFFFFFF80) | 32'h1;
            cfg_read(6'd5, rd); chk("R4 bar1 byte enables", rd, exp);
        end

        // R5 command
        cfg_write(6'd1, 4'h3, 32'h0000FFFF);
        cfg_read(6'd1, rd); chk("R5 cmd writable mask", rd & 32'hFFFF, 32'h0143);
        cfg_write(6'd1, 4'h1, 32'h0);
        cfg_read(6'd1, rd); chk("R5 cmd byte0 only", rd & 32'hFFFF, 32'h0100);
        cfg_write(6'd1, 4'h2, 32'h0);
        cfg_read(6'd1, rd); chk("R5 cmd byte1 only", rd & 32'hFFFF, 32'h0000);

        // R6 R7 R8 decode sweep
        for (int b = 0; b < 4; b++) begin
            cfg_write(6'd4, 4'hF, bases[b]);
            cfg_write(6'd5, 4'hF, bases[b] ^ 32'h00010000);
            for (int c = 0; c < 16; c++) begin
                cfg_write(6'd1, 4'h3, {30'h0, c[1], c[0]});
                bar0_en = c[2]; bar1_en = c[3];
                for (int side = 0; side < 2; side++) begin
                    logic [31:0] bb;
                    bb = (side == 0) ? bases[b] : (bases[b] ^ 32'h00010000);
                    probes[0] = bb; probes[1] = bb + 32'h7F; probes[2] = bb - 32'h1;
                    probes[3] = bb + 32'h80; probes[4] = bb ^ 32'h80000000;
                    for (int p = 0; p < 5; p++) begin
                        logic e;
                        if (side == 0) begin
                            mem_addr = probes[p]; #1;
                            e = c[1] && c[2] && (probes[p][31:7] == bb[31:7]);
                            chk(c[2] ? "R6 mem decode" : "R8 bar0 disabled", {31'h0, mem_hit}, {31'h0, e});
                        end else begin
                            io_addr = probes[p]; #1;
                            e = c[0] && c[3] && (probes[p][31:7] == bb[31:7]);
                            chk(c[3] ? "R7 io decode" : "R8 bar1 disabled", {31'h0, io_hit}, {31'h0, e});
                        end
                    end
                end
            end
        end
        cfg_write(6'd1, 4'h3, 32'h0);

        // R10 status
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); sts_evt = 5'(1 << i);
            @(negedge clk); sts_evt = '0;
            cfg_read(6'd1, rd); chk("R10 event sets", rd >> 27, 32'(1 << i));
            cfg_write(6'd1, 4'h7, 32'hFFFFFFFF);
            cfg_write(6'd1, 4'h3, 32'h0);
            cfg_read(6'd1, rd); chk("R10 no clear without be3", rd >> 27, 32'(1 << i));
            cfg_write(6'd1, 4'h8, 32'(1) << (27 + i));
            cfg_read(6'd1, rd); chk("R10 w1c clears", rd >> 27, 32'h0);
        end
        @(negedge clk); sts_evt = 5'h1F;
        @(negedge clk); sts_evt = '0;
        cfg_write(6'd1, 4'h8, 32'h50000000);
        cfg_read(6'd1, rd); chk("R10 partial clear", rd >> 27, 32'h15);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_num = 6'd1; cfg_be = 4'h8; cfg_wdata = 32'hF8000000; sts_evt = 5'h04;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0; sts_evt = '0;
        cfg_read(6'd1, rd); chk("R10 event wins over clear", rd >> 27, 32'h04);

        // R11 cache line
        cfg_write(6'd3, 4'h1, 32'hFFFFFF10);
        cfg_read(6'd3, rd); chk("R11 cache write", rd, 32'h10);
        cfg_write(6'd3, 4'hE, 32'h000000FF);
        cfg_read(6'd3, rd); chk("R11 cache be0 low", rd, 32'h10);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule